// File: doc/BRIEF.md
# Real-Time Clock Prescaler and Event Interrupt Core

This block is the control core of a PC-style real-time clock. It takes a one-cycle enable at the 32.768 kHz time-base rate and runs a 15-bit prescaler. The prescaler produces two events. One is a periodic tick whose rate is chosen by a four-bit code. The other is a once-per-second update strobe, which goes to a separate time-of-day counter. Software reaches three control registers through an index port and a data port. The index stays latched between accesses.

The event flags collect in a status register that is cleared by reading it. Each flag is combined with its enable to form a summary bit and the interrupt output. Any divider code other than "run" holds the prescaler at zero. Because of this, the first update strobe after release comes exactly half a second (16384 time-base ticks) later. A halt bit in the mode register stops update strobes and the update flag. The prescaler keeps counting while halted, so the once-per-second phase is kept. An alarm match input, driven by an alarm comparator outside this block, sets the alarm flag.

Top module: `rtc_ctl_core`

## Requirements
- R1: After reset, registers 0x0A, 0x0B and 0x0C read 0x00, and `irq`, `upd_strobe` and `halted` are low.
- R2: A write on the index port selects the register for every later data read or write until the index is written again. Register 0x0A is the rate/divider register, 0x0B the mode register and 0x0C the status register. Any other index reads 0x00 and ignores writes.
- R3: Bits 6:0 of register 0x0A and all bits of 0x0B read back as written. Bit 7 of 0x0A always reads 0. Writes to 0x0C have no effect.
- R4: The prescaler runs only while 0x0A bits 6:4 equal 3'b010. For any other value it is held at zero, and no periodic or update events occur.
- R5: The first update strobe comes 16384 time-base ticks after the divider is released. Each later strobe comes 32768 ticks after the one before.
- R6: 0x0A bits 3:0 (rate code c) select the periodic rate. For c from 3 to 15 the period is 2^(c-1) ticks. Codes 1 and 2 behave as codes 8 and 9. Code 0 gives no periodic events. Ticks fall on multiples of the period counted from release, so code 7 gives 256 periodic events up to and including the first update.
- R7: Changing the rate code while the divider runs does not move the update phase. Code 9 set after an update gives exactly 128 periodic events up to the next update.
- R8: Reading 0x0C returns the flags and clears them: periodic in bit 6, alarm in bit 5, update in bit 4. An event that arrives in the same cycle as the read is kept.
- R9: The flags set whether or not their enables are on. The enables are 0x0B bit 6 (periodic), bit 5 (alarm) and bit 4 (update). Bit 7 of 0x0C reads 1 exactly when some flag and its enable are both set.
- R10: `irq` is high while some flag and its matching enable are both set. The read of 0x0C that clears the flags drops it.
- R11: While 0x0B bit 7 is set, no update strobe is issued and the update flag does not set. The prescaler keeps running, so strobes resume on the original phase.
- R12: `upd_strobe` is a one-cycle pulse, and `halted` mirrors 0x0B bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_32k | input | 1 | One-cycle enable at the time-base rate |
| idx_wr | input | 1 | Write `wdata` to the index port |
| dat_wr | input | 1 | Write `wdata` to the indexed register |
| dat_rd | input | 1 | Read the indexed register into `rdata` |
| wdata | input | 8 | Write data |
| alarm_hit | input | 1 | Alarm match pulse from the external comparator |
| rdata | output | 8 | Read data, registered on `dat_rd` |
| irq | output | 1 | Interrupt request |
| upd_strobe | output | 1 | Once-per-second update pulse to the time counter |
| halted | output | 1 | Updates halted, for the time counter |

## Verification
The hardest cases to reach are the long-range timing properties. The strobe phase must survive a rate change and a halt, and the exact count of periodic flags within half a second must be right. Both need tens of thousands of time-base ticks, with software polling fast enough never to merge two periodic flags. The bench holds `tick_32k` high so that every cycle is one tick. It polls the status register every 16 cycles, well under the shortest period it uses. It keeps a free-running cycle count, so every observed strobe can be checked against its expected offset from the release write, both across the halt window and after the rate change.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;
  localparam int DATA_W   = 8;
  localparam int RATE_W   = 4;
  localparam int DIV_W    = 15;

  localparam logic [DATA_W-1:0] IDX_RATE   = 8'h0A;
  localparam logic [DATA_W-1:0] IDX_MODE   = 8'h0B;
  localparam logic [DATA_W-1:0] IDX_STATUS = 8'h0C;

  typedef enum logic [2:0] {
    DIVC_STOP0 = 3'b000,
    DIVC_ALT1  = 3'b001,
    DIVC_RUN   = 3'b010,
    DIVC_HOLD  = 3'b111
  } div_code_e;

  // positions of the three event kinds inside the status and enable fields
  localparam int EV_UPD = 0;
  localparam int EV_ALM = 1;
  localparam int EV_PER = 2;
  localparam int EV_N   = 3;
endpackage

// File: rtl/rtc_rate_dec.sv
module rtc_rate_dec
  import rtc_ctl_pkg::*;
#(
  parameter int CNT_W  = DIV_W,
  parameter int CODE_W = RATE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic              active,
  output logic [CNT_W-1:0]  mask
);
  localparam logic [CODE_W-1:0] ALIAS_OFS = CODE_W'(7);

  logic [CODE_W-1:0] eff;

  always_comb begin
    eff = code;
    if (code == CODE_W'(1) || code == CODE_W'(2)) eff = code + ALIAS_OFS;
    active = (code != '0);
    if (active) mask = (CNT_W'(1) << (eff - CODE_W'(1))) - CNT_W'(1);
    else        mask = '1;
  end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_ctl_pkg::*;
#(
  parameter int CNT_W  = DIV_W,
  parameter int CODE_W = RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              halt,
  input  logic [CODE_W-1:0] rate,
  output logic              per_evt,
  output logic              upd_evt
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] rmask;
  logic             ractive;
  logic             step;

  rtc_rate_dec #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_dec (
    .code   (rate),
    .active (ractive),
    .mask   (rmask)
  );

  assign step   = run && tick;
  assign cnt_nx = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      per_evt <= 1'b0;
      upd_evt <= 1'b0;
    end else begin
      if (!run)      cnt_q <= '0;
      else if (tick) cnt_q <= cnt_nx;
      per_evt <= step && ractive && ((cnt_nx & rmask) == '0);
      upd_evt <= step && !halt && (cnt_nx == HALF);
    end
  end
endmodule

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
  import rtc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_wr,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EV_N-1:0]   evt,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              div_run,
  output logic [RATE_W-1:0] rate,
  output logic              halt,
  output logic [EV_N-1:0]   ien,
  output logic              stat_rd
);
  localparam int EN_LO = 4;

  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-2:0] rate_q;
  logic [DATA_W-1:0] mode_q;
  logic [EV_N-1:0]   flg_q;

  logic [DATA_W-2:0] rate_n;
  logic [DATA_W-1:0] mode_n;
  logic [EV_N-1:0]   flg_n;
  logic [DATA_W-1:0] rd_val;
  logic              sel_rate, sel_mode, sel_stat;

  always_comb begin
    sel_rate = (idx_q == IDX_RATE);
    sel_mode = (idx_q == IDX_MODE);
    sel_stat = (idx_q == IDX_STATUS);
    stat_rd  = dat_rd && sel_stat;

    rate_n = rate_q;
    mode_n = mode_q;
    if (dat_wr && sel_rate) rate_n = wdata[DATA_W-2:0];
    if (dat_wr && sel_mode) mode_n = wdata;

    flg_n = (stat_rd ? '0 : flg_q) | evt;

    rd_val = '0;
    if (sel_rate)      rd_val = {1'b0, rate_q};
    else if (sel_mode) rd_val = mode_q;
    else if (sel_stat) rd_val = {|(flg_q & mode_q[EN_LO +: EV_N]), flg_q, 4'b0000};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      rate_q <= '0;
      mode_q <= '0;
      flg_q  <= '0;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      if (idx_wr) idx_q <= wdata;
      rate_q <= rate_n;
      mode_q <= mode_n;
      flg_q  <= flg_n;
      if (dat_rd) rdata <= rd_val;
      irq    <= |(flg_n & mode_n[EN_LO +: EV_N]);
    end
  end

  assign div_run = (rate_q[6:4] == DIVC_RUN);
  assign rate    = rate_q[RATE_W-1:0];
  assign halt    = mode_q[DATA_W-1];
  assign ien     = mode_q[EN_LO +: EV_N];
endmodule

// File: rtl/rtc_ctl_core.sv
module rtc_ctl_core
  import rtc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_32k,
  input  logic              idx_wr,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              alarm_hit,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              upd_strobe,
  output logic              halted
);
  logic              div_run;
  logic [RATE_W-1:0] rate;
  logic              halt;
  logic [EV_N-1:0]   ien;
  logic              stat_rd;
  logic              per_evt;
  logic              upd_evt;
  logic [EV_N-1:0]   evt;

  always_comb begin
    evt         = '0;
    evt[EV_PER] = per_evt;
    evt[EV_ALM] = alarm_hit;
    evt[EV_UPD] = upd_evt;
  end

  rtc_ctl_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .idx_wr  (idx_wr),
    .dat_wr  (dat_wr),
    .dat_rd  (dat_rd),
    .wdata   (wdata),
    .evt     (evt),
    .rdata   (rdata),
    .irq     (irq),
    .div_run (div_run),
    .rate    (rate),
    .halt    (halt),
    .ien     (ien),
    .stat_rd (stat_rd)
  );

  rtc_prescaler #(.CNT_W(DIV_W), .CODE_W(RATE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_32k),
    .run     (div_run),
    .halt    (halt),
    .rate    (rate),
    .per_evt (per_evt),
    .upd_evt (upd_evt)
  );

  assign upd_strobe = upd_evt;
  assign halted     = halt;
endmodule

// File: rtl/rtc_ctl_core_chk.sv
module rtc_ctl_core_chk
  import rtc_ctl_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            upd_strobe,
  input logic            halted,
  input logic            irq,
  input logic            alarm_hit,
  input logic            div_run,
  input logic            per_evt,
  input logic            stat_rd,
  input logic [EV_N-1:0] ien
);
  // R12: strobe lasts one cycle
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |=> !upd_strobe);

  // R11: no strobe is issued while halt was set in the previous cycle
  a_r11_halt_blocks: assert property (@(posedge clk) disable iff (rst)
    $past(halted) |-> !upd_strobe);

  // R4: held divider yields no events
  a_r4_held_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(div_run) |-> (!per_evt && !upd_strobe));

  // R9: interrupt needs at least one enable
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ien != '0));

  // R10: a status read with no new events drops the interrupt
  a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !per_evt && !upd_strobe && !alarm_hit) |=> !irq);
endmodule

bind rtc_ctl_core rtc_ctl_core_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .upd_strobe (upd_strobe),
  .halted     (halted),
  .irq        (irq),
  .alarm_hit  (alarm_hit),
  .div_run    (div_run),
  .per_evt    (per_evt),
  .stat_rd    (stat_rd),
  .ien        (ien)
);

// File: tb/rtc_ctl_core_tb.sv
module rtc_ctl_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_T     = 16384;
  localparam int FULL_T     = 32768;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_32k = 1'b1;
  logic       idx_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0, alarm_hit = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, upd_strobe, halted;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_strobe = -1;
  int strobe_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_ctl_core dut_i (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .dat_rd(dat_rd), .wdata(wdata), .alarm_hit(alarm_hit), .rdata(rdata),
    .irq(irq), .upd_strobe(upd_strobe), .halted(halted)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (upd_strobe) begin
      last_strobe <= cyc;
      strobe_cnt  <= strobe_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_idx(input logic [7:0] v);
    @(negedge clk); idx_wr = 1'b1; wdata = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic rd_dat(output logic [7:0] v);
    @(negedge clk); dat_rd = 1'b1;
    @(negedge clk); dat_rd = 1'b0; v = rdata;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] v);
    wr_idx(i); wr_dat(v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", int'(irq), 0);
    chk("R1 strobe", int'(upd_strobe), 0);
    chk("R1 halted", int'(halted), 0);
    wr_idx(8'h0A); rd_dat(v); chk("R1 rate reg", v, 0);
    wr_idx(8'h0B); rd_dat(v); chk("R1 mode reg", v, 0);
    wr_idx(8'h0C); rd_dat(v); chk("R1 status reg", v, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr_idx(8'h0A);
    wr_dat(8'h76); rd_dat(v); chk("R2 latched index rate", v, 8'h76);
    wr_dat(8'hF5); rd_dat(v); chk("R3 rate bit7 reads 0", v, 8'h75);
    wr_dat(8'h70);
    wr_idx(8'h0B);
    wr_dat(8'h06); rd_dat(v); chk("R3 mode readback", v, 8'h06);
    wr_dat(8'h00); rd_dat(v); chk("R2 repeat data access", v, 8'h00);
    wr_idx(8'h0C); wr_dat(8'hF0); rd_dat(v); chk("R3 status write ignored", v, 0);
    wr_idx(8'h20); wr_dat(8'h5A); rd_dat(v); chk("R2 unmapped index", v, 0);
    wr_idx(8'h0A); rd_dat(v); chk("R2 unmapped write no effect", v, 8'h70);
  endtask

  task automatic t_held();
    logic [7:0] v;
    wr_reg(8'h0A, 8'h73);
    wr_idx(8'h0C); rd_dat(v);
    repeat (3000) @(negedge clk);
    rd_dat(v); chk("R4 divider 111 no flags", v, 0);
    wr_reg(8'h0A, 8'h13);
    wr_idx(8'h0C);
    repeat (3000) @(negedge clk);
    rd_dat(v); chk("R4 divider 001 no flags", v, 0);
    chk("R4 no strobe while held", strobe_cnt, 0);
  endtask

  task automatic t_periodic();
    logic [7:0] v;
    int rel, npf, s1;
    wr_reg(8'h0A, 8'h70); wr_reg(8'h0B, 8'h00);
    wr_idx(8'h0C); rd_dat(v);
    wr_reg(8'h0A, 8'h27);
    rel = cyc;
    wr_idx(8'h0C);
    npf = 0;
    do begin
      rd_dat(v);
      if (v[6]) npf++;
      if (v[7]) chk("R9 summary bit clear without enables", int'(v[7]), 0);
      repeat (15) @(negedge clk);
    end while (!v[4]);
    chk("R6 code 7 flags before first update", npf, 256);
    s1 = last_strobe;
    chk("R5 first update offset", s1 - rel, HALF_T);
    wr_reg(8'h0A, 8'h29);
    wr_idx(8'h0C);
    npf = 0;
    do begin
      rd_dat(v);
      if (v[6]) npf++;
      repeat (15) @(negedge clk);
    end while (!v[4]);
    chk("R7 code 9 flags between updates", npf, 128);
    chk("R5 R7 update spacing after rate change", last_strobe - s1, FULL_T);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    int k;
    wr_reg(8'h0A, 8'h70); wr_reg(8'h0B, 8'h00);
    wr_idx(8'h0C); rd_dat(v);
    wr_reg(8'h0A, 8'h23);
    repeat (40) @(negedge clk);
    chk("R9 no irq with enables off", int'(irq), 0);
    wr_idx(8'h0C); rd_dat(v);
    chk("R9 periodic flag without enable", int'(v[6]), 1);
    chk("R9 summary bit clear", int'(v[7]), 0);
    wr_reg(8'h0B, 8'h40);
    k = 0;
    while (!irq && k < 40) begin @(negedge clk); k++; end
    chk("R10 irq with periodic enable", int'(irq), 1);
    wr_reg(8'h0A, 8'h70);
    wr_idx(8'h0C); rd_dat(v);
    chk("R9 R8 status periodic plus summary", int'(v & 8'hC0), 8'hC0);
    chk("R10 irq dropped by read", int'(irq), 0);
    rd_dat(v); chk("R8 second read empty", v, 0);
    wr_reg(8'h0B, 8'h20);
    wr_idx(8'h0C);
    @(negedge clk); alarm_hit = 1'b1;
    @(negedge clk); alarm_hit = 1'b0;
    chk("R10 irq from alarm", int'(irq), 1);
    @(negedge clk); dat_rd = 1'b1; alarm_hit = 1'b1;
    @(negedge clk); dat_rd = 1'b0; alarm_hit = 1'b0; v = rdata;
    chk("R8 alarm read value", v, 8'hA0);
    chk("R8 coincident event kept irq", int'(irq), 1);
    rd_dat(v); chk("R8 coincident event kept flag", v, 8'hA0);
    chk("R10 irq low after final read", int'(irq), 0);
    wr_reg(8'h0B, 8'h00);
  endtask

  task automatic t_halt();
    logic [7:0] v;
    int rel, c0;
    wr_reg(8'h0A, 8'h70); wr_reg(8'h0B, 8'h80);
    chk("R12 halted mirrors mode bit7", int'(halted), 1);
    wr_idx(8'h0C); rd_dat(v);
    c0 = strobe_cnt;
    wr_reg(8'h0A, 8'h26);
    rel = cyc;
    repeat (20000) @(negedge clk);
    chk("R11 no strobe while halted", strobe_cnt - c0, 0);
    wr_idx(8'h0C); rd_dat(v);
    chk("R11 periodic yes update no while halted", int'(v & 8'h50), 8'h40);
    wr_reg(8'h0B, 8'h00);
    chk("R12 halted released", int'(halted), 0);
    while (strobe_cnt == c0 && cyc - rel < HALF_T + FULL_T + 100) @(negedge clk);
    @(negedge clk);
    chk("R11 phase kept across halt", last_strobe - rel, HALF_T + FULL_T);
    wr_reg(8'h0A, 8'h70);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_held();
    t_periodic();
    t_irq();
    t_halt();
    finish_run();
  end
endmodule